// File: doc/BRIEF.md
# Floating-point deferred trap queue

This block keeps a record of floating-point instructions that went to an asynchronous FP pipeline and have not yet finished. Each record pairs the instruction's address with its instruction word. At issue the block gives the instruction a slot tag. When the instruction finishes normally, the pipeline returns that tag and the block deletes the record.

If the pipeline reports a floating-point exception against a tag, the queue freezes and raises a one-cycle trap request. The faulting record moves to the head of the queue. The other unfinished records follow it in the order they were issued. While the queue is frozen it takes no new instructions. Privileged trap software then reads the records out one 64-bit word per request, and keeps going until the not-empty flag drops. The block leaves the frozen state once the last record has been read.

The depth is a parameter. A depth of zero describes a synchronous pipeline: the block then stores nothing and never reports content.

Top module: `fp_defer_queue`

## Requirements
- R1: A drained 64-bit word carries the instruction address in bits [63:32] and the instruction word in bits [31:0].
- R2: An issue is accepted in the cycle `iss_valid` and `iss_ready` are both high. The `iss_tag` presented in that cycle differs from the tags of all live entries. `q_not_empty` is high from the cycle after an accept for as long as any entry remains.
- R3: A completion with `cmp_exc` low deletes the entry holding `cmp_tag`. The other entries keep their issue order, so completions may arrive in any order. A tag that matches no live entry has no effect.
- R4: A completion with `cmp_exc` high against a live tag freezes the queue. `trap_req` is high for exactly the one cycle after that completion.
- R5: After the freeze, the faulting entry is drained first. The remaining entries follow in their original issue order.
- R6: While frozen, `iss_ready` is low and issues are dropped. Completions are ignored.
- R7: A privileged drain (`drn_req` and `drn_priv` high) while frozen raises `drn_valid` in the next cycle, with the head entry on `drn_data`, and deletes that entry.
- R8: The frozen state ends together with the drain of the last entry. In the cycle after that drain, `q_not_empty` is low and `iss_ready` is high.
- R9: A privileged drain while the queue is not frozen (this includes an empty queue) returns no data. It pulses `drn_seq_err` in the next cycle and leaves the queue unchanged.
- R10: A drain with `drn_priv` low pulses `drn_priv_err` in the next cycle, returns no data and leaves the queue unchanged.
- R11: With DEPTH = 0, `iss_ready` is always high, `q_not_empty` is always low, and every privileged drain gives a sequence error.
- R12: When DEPTH entries are live, `iss_ready` is low and an issue attempt is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | FP instruction offered for issue |
| iss_addr | input | 32 | Address of the offered instruction |
| iss_insn | input | 32 | Instruction word of the offered instruction |
| iss_ready | output | 1 | Queue accepts an issue this cycle |
| iss_tag | output | TW | Slot tag given to an accepted issue |
| cmp_valid | input | 1 | Pipeline reports an instruction finished |
| cmp_tag | input | TW | Tag of the finished instruction |
| cmp_exc | input | 1 | The finished instruction raised an exception |
| drn_req | input | 1 | Drain request from trap software |
| drn_priv | input | 1 | Requester is in privileged mode |
| drn_valid | output | 1 | Drained entry is valid |
| drn_data | output | 64 | Drained entry: address in high half, instruction in low half |
| drn_seq_err | output | 1 | Drain made while the queue is not frozen |
| drn_priv_err | output | 1 | Drain made without privilege |
| trap_req | output | 1 | One-cycle pulse when the queue freezes |
| q_not_empty | output | 1 | At least one entry is held |

## Verification
Completions arrive out of issue order against a full queue, so deletion from the middle is checked apart from deletion at either end. An exception is raised on the youngest entry, so the move to the head is checked apart from plain FIFO order. Issues and completions offered during the freeze, together with unprivileged and out-of-state drains, show that each of these leaves the stored order intact. A long random mix of issues, in-order and out-of-order completions, stale tags and exceptions is compared against a reference queue held in the bench. A second instance with depth zero shows the synchronous behaviour.

// File: rtl/fpdq_pkg.sv
package fpdq_pkg;
    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] insn;
    } fq_entry_t;

    function automatic int unsigned idx_w(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/fpdq_alloc.sv
module fpdq_alloc #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned TW    = 1,
    parameter int unsigned CW    = 2
) (
    input  logic [DEPTH-1:0][TW-1:0] tags,
    input  logic [CW-1:0]            cnt,
    output logic [TW-1:0]            free_id
);
    logic [DEPTH-1:0] used;

    always_comb begin
        used = '0;
        for (int k = 0; k < DEPTH; k++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i < int'(cnt) && tags[i] == TW'(k)) used[k] = 1'b1;
            end
        end
        free_id = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (!used[k]) free_id = TW'(k);
        end
    end
endmodule

// File: rtl/fpdq_match.sv
module fpdq_match #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned TW    = 1,
    parameter int unsigned CW    = 2
) (
    input  logic [DEPTH-1:0][TW-1:0] tags,
    input  logic [CW-1:0]            cnt,
    input  logic [TW-1:0]            key,
    output logic                     hit,
    output logic [TW-1:0]            pos
);
    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (i < int'(cnt) && tags[i] == key) begin
                hit = 1'b1;
                pos = TW'(i);
            end
        end
    end
endmodule

// File: rtl/fp_defer_queue.sv
module fp_defer_queue
    import fpdq_pkg::*;
#(
    parameter  int unsigned DEPTH = 2,
    localparam int unsigned TW    = idx_w(DEPTH),
    localparam int unsigned CW    = idx_w(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [31:0]   iss_addr,
    input  logic [31:0]   iss_insn,
    output logic          iss_ready,
    output logic [TW-1:0] iss_tag,
    input  logic          cmp_valid,
    input  logic [TW-1:0] cmp_tag,
    input  logic          cmp_exc,
    input  logic          drn_req,
    input  logic          drn_priv,
    output logic          drn_valid,
    output logic [63:0]   drn_data,
    output logic          drn_seq_err,
    output logic          drn_priv_err,
    output logic          trap_req,
    output logic          q_not_empty
);
    if (DEPTH == 0) begin : g_sync
        logic serr_q, perr_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                serr_q <= 1'b0;
                perr_q <= 1'b0;
            end else begin
                serr_q <= drn_req && drn_priv;
                perr_q <= drn_req && !drn_priv;
            end
        end

        assign iss_ready    = 1'b1;
        assign iss_tag      = '0;
        assign drn_valid    = 1'b0;
        assign drn_data     = '0;
        assign drn_seq_err  = serr_q;
        assign drn_priv_err = perr_q;
        assign trap_req     = 1'b0;
        assign q_not_empty  = 1'b0;
    end else begin : g_async
        typedef struct packed {
            fq_entry_t [DEPTH-1:0]       ent;
            logic [DEPTH-1:0][TW-1:0]    tag;
            logic [CW-1:0]               cnt;
            logic                        frozen;
            logic                        trap;
            logic                        dval;
            fq_entry_t                   dat;
            logic                        serr;
            logic                        perr;
        } state_t;

        state_t        s_d, s_q;
        logic [TW-1:0] free_id;
        logic          hit;
        logic [TW-1:0] hit_pos;
        logic          issue_ok;

        fpdq_alloc #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_alloc (
            .tags    (s_q.tag),
            .cnt     (s_q.cnt),
            .free_id (free_id)
        );

        fpdq_match #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_match (
            .tags (s_q.tag),
            .cnt  (s_q.cnt),
            .key  (cmp_tag),
            .hit  (hit),
            .pos  (hit_pos)
        );

        assign issue_ok = !s_q.frozen && (s_q.cnt < CW'(DEPTH));

        always_comb begin
            fq_entry_t     mv_ent;
            logic [TW-1:0] mv_tag;
            s_d      = s_q;
            s_d.trap = 1'b0;
            s_d.dval = 1'b0;
            s_d.serr = 1'b0;
            s_d.perr = 1'b0;
            mv_ent   = s_q.ent[hit_pos];
            mv_tag   = s_q.tag[hit_pos];

            if (drn_req && !drn_priv) begin
                s_d.perr = 1'b1;
            end else if (drn_req && !s_q.frozen) begin
                s_d.serr = 1'b1;
            end

            if (!s_q.frozen) begin
                if (cmp_valid && hit) begin
                    if (cmp_exc) begin
                        // faulting entry to the head, older ones slide up
                        for (int i = 1; i < DEPTH; i++) begin
                            if (i <= int'(hit_pos)) begin
                                s_d.ent[i] = s_q.ent[i-1];
                                s_d.tag[i] = s_q.tag[i-1];
                            end
                        end
                        s_d.ent[0] = mv_ent;
                        s_d.tag[0] = mv_tag;
                        s_d.frozen = 1'b1;
                        s_d.trap   = 1'b1;
                    end else begin
                        for (int i = 0; i < DEPTH - 1; i++) begin
                            if (i >= int'(hit_pos)) begin
                                s_d.ent[i] = s_q.ent[i+1];
                                s_d.tag[i] = s_q.tag[i+1];
                            end
                        end
                        s_d.cnt = s_d.cnt - CW'(1);
                    end
                end
                if (iss_valid && issue_ok) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (i == int'(s_d.cnt)) begin
                            s_d.ent[i] = '{addr: iss_addr, insn: iss_insn};
                            s_d.tag[i] = free_id;
                        end
                    end
                    s_d.cnt = s_d.cnt + CW'(1);
                end
            end else if (drn_req && drn_priv) begin
                s_d.dval = 1'b1;
                s_d.dat  = s_q.ent[0];
                for (int i = 0; i < DEPTH - 1; i++) begin
                    s_d.ent[i] = s_q.ent[i+1];
                    s_d.tag[i] = s_q.tag[i+1];
                end
                s_d.cnt = s_q.cnt - CW'(1);
                if (s_q.cnt == CW'(1)) s_d.frozen = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign iss_ready    = issue_ok;
        assign iss_tag      = free_id;
        assign drn_valid    = s_q.dval;
        assign drn_data     = s_q.dat;
        assign drn_seq_err  = s_q.serr;
        assign drn_priv_err = s_q.perr;
        assign trap_req     = s_q.trap;
        assign q_not_empty  = (s_q.cnt != '0);
    end
endmodule

// File: rtl/fpdq_checker.sv
module fpdq_checker #(
    parameter int unsigned DEPTH = 2
) (
    input logic clk,
    input logic rst_n,
    input logic iss_ready,
    input logic drn_req,
    input logic drn_priv,
    input logic drn_valid,
    input logic drn_seq_err,
    input logic drn_priv_err,
    input logic trap_req,
    input logic q_not_empty
);
    a_r4_trap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    a_r4_trap_holds_entry: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> q_not_empty);

    a_r6_no_issue_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !iss_ready);

    a_r7_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        drn_valid |-> $past(drn_req && drn_priv));

    a_r10_priv_cause: assert property (@(posedge clk) disable iff (!rst_n)
        drn_priv_err |-> $past(drn_req && !drn_priv));

    a_r9_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drn_valid, drn_seq_err, drn_priv_err}));

    a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_not_empty) |-> iss_ready);

    a_r11_sync_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (DEPTH != 0) || (!q_not_empty && iss_ready));
endmodule

bind fp_defer_queue fpdq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_ready    (iss_ready),
    .drn_req      (drn_req),
    .drn_priv     (drn_priv),
    .drn_valid    (drn_valid),
    .drn_seq_err  (drn_seq_err),
    .drn_priv_err (drn_priv_err),
    .trap_req     (trap_req),
    .q_not_empty  (q_not_empty)
);

// File: tb/fp_defer_queue_test.sv
`timescale 1ns/1ps
module fp_defer_queue_test;
    localparam int D = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        iss_valid;
    logic [31:0] iss_addr, iss_insn;
    logic        iss_ready;
    logic [1:0]  iss_tag;
    logic        cmp_valid;
    logic [1:0]  cmp_tag;
    logic        cmp_exc;
    logic        drn_req, drn_priv;
    logic        drn_valid;
    logic [63:0] drn_data;
    logic        drn_seq_err, drn_priv_err, trap_req, q_not_empty;

    logic        z_ready, z_tag, z_valid, z_serr, z_perr, z_trap, z_ne;
    logic [63:0] z_data;

    always #2 clk = ~clk;

    fp_defer_queue #(.DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_addr(iss_addr),
        .iss_insn(iss_insn), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_exc(cmp_exc),
        .drn_req(drn_req), .drn_priv(drn_priv), .drn_valid(drn_valid),
        .drn_data(drn_data), .drn_seq_err(drn_seq_err), .drn_priv_err(drn_priv_err),
        .trap_req(trap_req), .q_not_empty(q_not_empty)
    );

    fp_defer_queue #(.DEPTH(0)) uut0 (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_addr(iss_addr),
        .iss_insn(iss_insn), .iss_ready(z_ready), .iss_tag(z_tag),
        .cmp_valid(cmp_valid), .cmp_tag(1'b0), .cmp_exc(cmp_exc),
        .drn_req(drn_req), .drn_priv(drn_priv), .drn_valid(z_valid),
        .drn_data(z_data), .drn_seq_err(z_serr), .drn_priv_err(z_perr),
        .trap_req(z_trap), .q_not_empty(z_ne)
    );

    // reference queue
    logic [31:0] m_a [16];
    logic [31:0] m_i [16];
    logic [1:0]  m_t [16];
    int          m_n;
    bit          m_fz;
    int          checks = 0;
    int          errs   = 0;

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    function automatic bit exp_ready();
        return !m_fz && m_n < D;
    endfunction

    task automatic do_issue(input logic [31:0] a, input logic [31:0] ins);
        bit rdy = exp_ready();
        chk("R12 issue ready", iss_ready, rdy);
        if (rdy) begin
            bit dup = 0;
            for (int k = 0; k < m_n; k++) if (m_t[k] == iss_tag) dup = 1;
            chk("R2 tag unique", dup, 0);
            m_a[m_n] = a; m_i[m_n] = ins; m_t[m_n] = iss_tag; m_n++;
        end
        iss_valid = 1; iss_addr = a; iss_insn = ins;
        @(negedge clk);
        iss_valid = 0;
        chk("R2 not empty", q_not_empty, m_n != 0);
    endtask

    task automatic do_cmp(input logic [1:0] t, input bit exc);
        bit tr = 0;
        if (!m_fz) begin
            int p = -1;
            for (int k = m_n - 1; k >= 0; k--) if (m_t[k] == t) p = k;
            if (p >= 0) begin
                logic [31:0] sa = m_a[p], si = m_i[p];
                logic [1:0]  st = m_t[p];
                if (exc) begin
                    for (int k = p; k > 0; k--) begin
                        m_a[k] = m_a[k-1]; m_i[k] = m_i[k-1]; m_t[k] = m_t[k-1];
                    end
                    m_a[0] = sa; m_i[0] = si; m_t[0] = st;
                    m_fz = 1; tr = 1;
                end else begin
                    for (int k = p; k < m_n - 1; k++) begin
                        m_a[k] = m_a[k+1]; m_i[k] = m_i[k+1]; m_t[k] = m_t[k+1];
                    end
                    m_n--;
                end
            end
        end
        cmp_valid = 1; cmp_tag = t; cmp_exc = exc;
        @(negedge clk);
        cmp_valid = 0; cmp_exc = 0;
        chk("R4 trap pulse", trap_req, tr);
        chk("R6 ready", iss_ready, exp_ready());
        chk("R3 not empty", q_not_empty, m_n != 0);
    endtask

    task automatic do_drain(input bit priv);
        drn_req = 1; drn_priv = priv;
        @(negedge clk);
        drn_req = 0; drn_priv = 0;
        if (!priv) begin
            chk("R10 priv err", drn_priv_err, 1);
            chk("R10 no data", drn_valid, 0);
            chk("R11 z priv err", z_perr, 1);
        end else begin
            chk("R11 z seq err", z_serr, 1);
            chk("R11 z empty", z_ne, 0);
            chk("R11 z ready", z_ready, 1);
            if (m_fz) begin
                chk("R7 drain valid", drn_valid, 1);
                chk("R1 R5 drained word", drn_data, {m_a[0], m_i[0]});
                for (int k = 0; k < m_n - 1; k++) begin
                    m_a[k] = m_a[k+1]; m_i[k] = m_i[k+1]; m_t[k] = m_t[k+1];
                end
                m_n--;
                if (m_n == 0) m_fz = 0;
            end else begin
                chk("R9 seq err", drn_seq_err, 1);
                chk("R9 no data", drn_valid, 0);
            end
        end
        chk("R8 ready", iss_ready, exp_ready());
        chk("R8 not empty", q_not_empty, m_n != 0);
    endtask

    initial begin
        #(4 * 200000);
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0F1A));
        rst_n = 0; iss_valid = 0; iss_addr = 0; iss_insn = 0;
        cmp_valid = 0; cmp_tag = 0; cmp_exc = 0; drn_req = 0; drn_priv = 0;
        m_n = 0; m_fz = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2 reset ready", iss_ready, 1);
        chk("R2 reset empty", q_not_empty, 0);
        chk("R4 reset trap", trap_req, 0);
        chk("R11 reset z ready", z_ready, 1);

        do_drain(1);                                   // R9 empty
        do_issue(32'h1000_0000, 32'hA000_0001);
        do_issue(32'h1000_0004, 32'hA000_0002);
        do_issue(32'h1000_0008, 32'hA000_0003);
        do_issue(32'h1000_000C, 32'hA000_0004);        // R12 dropped when full
        do_drain(1);                                   // R9 not frozen, non-empty
        do_cmp(m_t[1], 0);                             // R3 middle removal
        do_cmp(2'd3, 0);                               // R3 unknown tag ignored
        do_issue(32'h1000_0010, 32'hA000_0005);
        do_cmp(m_t[2], 1);                             // R4 R5 youngest faults
        do_issue(32'h1000_0014, 32'hA000_0006);        // R6 dropped while frozen
        do_cmp(m_t[1], 0);                             // R6 completion ignored
        do_drain(0);                                   // R10
        do_drain(1); do_drain(1); do_drain(1);         // R1 R5 R7 R8
        do_drain(1);                                   // R9 again

        for (int n = 0; n < 3000; n++) begin
            int r = $urandom % 10;
            if (m_fz) begin
                if (r < 1)      do_drain(0);
                else if (r < 2) do_cmp(2'($urandom), 0);
                else if (r < 3) do_issue($urandom, $urandom);
                else            do_drain(1);
            end else begin
                if (r < 4) do_issue($urandom, $urandom);
                else if (r < 7 && m_n > 0) do_cmp(m_t[$urandom % m_n], ($urandom % 8) == 0);
                else if (r < 8) do_cmp(2'($urandom), 0);
                else if (r < 9) do_drain(1'($urandom));
                else begin
                    @(negedge clk);
                    chk("R2 idle not empty", q_not_empty, m_n != 0);
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule